// File: doc/BRIEF.md
# Register Rename and In-Order Commit Unit

This block gives each micro-operation that writes one of the 8 architectural integer registers a new physical register. The pool holds 48 physical registers: 8 hold the committed values and 40 more are for speculative results. A source operand is renamed to the physical register most recently assigned to its architectural register. True dependencies are kept, and write-after-write and write-after-read hazards caused by register reuse disappear. Up to three micro-operations enter per cycle as one group. A later slot in a group sees the destinations of earlier slots in the same group.

Each accepted micro-operation takes one entry in a circular reorder buffer of 64 entries. An execution back end reports completions by buffer index, in any order. A commit pointer follows the allocation pointer around the buffer. Each cycle it commits a contiguous run of up to three completed entries, in program order. Committing an entry updates the committed mapping and returns the register that held the previous value of that destination to the free pool. A flush input throws away all speculative work. It restores the committed mapping, empties the buffer and returns every speculative register to the pool.

Top module: `rename_commit_unit`

## Requirements
- R1: After reset, architectural register a maps to physical register a and is ready. The buffer is empty, `alloc_ready_o` is 1 and `ret_valid_o` is 0.
- R2: A source tag is the physical register most recently assigned to that architectural register. An earlier valid slot of the same group that writes the register takes precedence, and a tag taken from such a slot has its ready bit at 0.
- R3: Every destination in an accepted group gets a distinct physical register that is currently free. These are the lowest-numbered free registers, handed out in ascending order to the destination-writing slots in slot order. `dst_tag_o` shows the tag for each slot.
- R4: Buffer indices are handed out consecutively from the allocation pointer to the valid slots in slot order, skipping invalid slots. The pointer wraps modulo 64.
- R5: A completion marks its buffer entry done and its destination register ready. Source ready bits reflect completions from earlier cycles.
- R6: Each cycle, commit covers the contiguous entries starting at the commit pointer, up to 3 of them, and stops at the first entry that is not done. `ret_valid_o` is always a prefix: bit k set implies bit k-1 set.
- R7: On commit of an entry with a destination, `ret_free_tag_o` gives the register that previously held that architectural register. That register becomes free for later allocation.
- R8: `alloc_ready_o` is 0 when the free pool has fewer registers than the group has destinations, or when the buffer has fewer empty entries than the group has valid slots. A group that is not accepted changes no state.
- R9: A flush cycle accepts no group and commits nothing. In the next cycle the speculative mapping equals the committed mapping, the buffer is empty with both pointers at 0, every register outside the committed mapping is free, and all mapped registers are ready.
- R10: An entry that completes before an older incomplete entry is not committed until the older entry has completed and been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard all speculative state |
| alloc_valid_i | input | 3 | Slot carries a micro-op |
| alloc_dst_en_i | input | 3 | Slot writes a destination register |
| alloc_dst_i | input | 3x3 | Destination architectural register per slot |
| alloc_src_a_i | input | 3x3 | First source architectural register per slot |
| alloc_src_b_i | input | 3x3 | Second source architectural register per slot |
| alloc_ready_o | output | 1 | Whole group is accepted this cycle |
| alloc_idx_o | output | 3x6 | Buffer index per slot |
| dst_tag_o | output | 3x6 | New physical destination per slot |
| src_a_tag_o | output | 3x6 | Renamed first source |
| src_a_rdy_o | output | 3 | First source value available |
| src_b_tag_o | output | 3x6 | Renamed second source |
| src_b_rdy_o | output | 3 | Second source value available |
| wb_valid_i | input | 3 | Completion report valid |
| wb_idx_i | input | 3x6 | Buffer index of the completed micro-op |
| ret_valid_o | output | 3 | Entry commits this cycle |
| ret_arch_o | output | 3x3 | Committed architectural destination |
| ret_tag_o | output | 3x6 | Committed physical destination |
| ret_free_o | output | 3 | Committed entry releases a register |
| ret_free_tag_o | output | 3x6 | Released physical register |

## Verification
The hardest state to reach from the ports is exhaustion. With 64 buffer entries and only 40 spare registers, the free pool runs dry before the buffer can fill. A full buffer is reached only by streaming micro-ops that write no destination. Pool exhaustion needs thirteen full groups of writers followed by mixed groups that straddle the last free register. Flush is checked in a cycle where a completed entry is waiting to commit, after an earlier commit has moved the committed mapping away from reset. This proves that commit is suppressed and that the recovered mapping and free pool come from committed state and not from reset state.

// File: rtl/rr_pkg.sv
package rr_pkg;
  parameter int ARCH_REGS  = 8;
  parameter int EXTRA_REGS = 40;
  parameter int PHYS_REGS  = ARCH_REGS + EXTRA_REGS;
  parameter int ROB_DEPTH  = 64;
  parameter int GROUP      = 3;

  localparam int AW  = $clog2(ARCH_REGS);
  localparam int PW  = $clog2(PHYS_REGS);
  localparam int IW  = $clog2(ROB_DEPTH);
  localparam int CW  = IW + 1;
  localparam int FCW = $clog2(PHYS_REGS + 1);
  localparam int GCW = $clog2(GROUP + 1);

  typedef logic [AW-1:0] arch_t;
  typedef logic [PW-1:0] phys_t;
  typedef logic [IW-1:0] idx_t;

  typedef struct packed {
    logic  done;
    logic  dst_en;
    arch_t arch;
    phys_t new_p;
    phys_t old_p;
  } rob_ent_t;
endpackage

// File: rtl/rr_free_list.sv
module rr_free_list
  import rr_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [GCW-1:0]           take_cnt_i,
  input  logic [GROUP-1:0]         rel_en_i,
  input  phys_t [GROUP-1:0]        rel_tag_i,
  input  phys_t [ARCH_REGS-1:0]    commit_map_i,
  output phys_t [GROUP-1:0]        pick_o,
  output logic [FCW-1:0]           free_cnt_o
);
  logic [PHYS_REGS-1:0] free_q, free_d, mask;

  // lowest free registers, one per potential destination slot
  always_comb begin
    mask = free_q;
    for (int k = 0; k < GROUP; k++) begin
      pick_o[k] = '0;
      for (int p = PHYS_REGS - 1; p >= 0; p--)
        if (mask[p]) pick_o[k] = PW'(p);
      mask[pick_o[k]] = 1'b0;
    end
  end

  assign free_cnt_o = FCW'($countones(free_q));

  always_comb begin
    free_d = free_q;
    for (int k = 0; k < GROUP; k++)
      if (GCW'(k) < take_cnt_i) free_d[pick_o[k]] = 1'b0;
    for (int k = 0; k < GROUP; k++)
      if (rel_en_i[k]) free_d[rel_tag_i[k]] = 1'b1;
    if (flush_i) begin
      free_d = '1;
      for (int a = 0; a < ARCH_REGS; a++) free_d[commit_map_i[a]] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PHYS_REGS; p++) free_q[p] <= (p >= ARCH_REGS);
    end else begin
      free_q <= free_d;
    end
  end

  // R8: never hand out more than is free
  a_r8_take_within_pool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    FCW'(take_cnt_i) <= free_cnt_o);

  for (genvar k = 0; k < GROUP; k++) begin : g_rel_chk
    // R7: a released register must currently be in use
    a_r7_no_double_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_en_i[k] && !flush_i) |-> !free_q[rel_tag_i[k]]);
  end
endmodule

// File: rtl/rr_alias_table.sv
module rr_alias_table
  import rr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [GROUP-1:0]       spec_we_i,
  input  arch_t [GROUP-1:0]      spec_arch_i,
  input  phys_t [GROUP-1:0]      spec_phys_i,
  input  logic [GROUP-1:0]       com_we_i,
  input  arch_t [GROUP-1:0]      com_arch_i,
  input  phys_t [GROUP-1:0]      com_phys_i,
  output phys_t [ARCH_REGS-1:0]  spec_map_o,
  output phys_t [ARCH_REGS-1:0]  com_map_o
);
  phys_t [ARCH_REGS-1:0] spec_q, com_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        spec_q[a] <= PW'(a);
        com_q[a]  <= PW'(a);
      end
    end else if (flush_i) begin
      spec_q <= com_q;
    end else begin
      // later slots override earlier ones
      for (int k = 0; k < GROUP; k++) begin
        if (spec_we_i[k]) spec_q[spec_arch_i[k]] <= spec_phys_i[k];
        if (com_we_i[k])  com_q[com_arch_i[k]]   <= com_phys_i[k];
      end
    end
  end

  assign spec_map_o = spec_q;
  assign com_map_o  = com_q;

  a_r9_flush_restores_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (spec_q == com_q));
  a_r9_flush_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (com_we_i == '0));
endmodule

// File: rtl/rr_rob.sv
module rr_rob
  import rr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 alloc_fire_i,
  input  logic [GROUP-1:0]     alloc_valid_i,
  input  rob_ent_t [GROUP-1:0] alloc_ent_i,
  input  logic [GROUP-1:0]     wb_valid_i,
  input  idx_t [GROUP-1:0]     wb_idx_i,
  output idx_t [GROUP-1:0]     alloc_idx_o,
  output logic [CW-1:0]        space_o,
  output logic [GROUP-1:0]     ret_valid_o,
  output rob_ent_t [GROUP-1:0] ret_ent_o,
  output phys_t [GROUP-1:0]    wb_phys_o,
  output logic [GROUP-1:0]     wb_dst_en_o
);
  rob_ent_t ent_q [ROB_DEPTH];
  idx_t head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [GCW-1:0] n_alloc, n_ret;

  always_comb begin
    n_alloc = '0;
    for (int k = 0; k < GROUP; k++) begin
      alloc_idx_o[k] = tail_q + idx_t'(n_alloc);
      if (alloc_valid_i[k]) n_alloc = n_alloc + 1'b1;
    end
    if (!alloc_fire_i) n_alloc = '0;
  end

  // commit stops at first incomplete entry
  always_comb begin
    logic run;
    run   = !flush_i;
    n_ret = '0;
    for (int k = 0; k < GROUP; k++) begin
      ret_ent_o[k]   = ent_q[head_q + idx_t'(k)];
      ret_valid_o[k] = run && (CW'(k) < cnt_q) && ret_ent_o[k].done;
      run            = ret_valid_o[k];
      if (ret_valid_o[k]) n_ret = n_ret + 1'b1;
    end
  end

  for (genvar k = 0; k < GROUP; k++) begin : g_wb
    assign wb_phys_o[k]   = ent_q[wb_idx_i[k]].new_p;
    assign wb_dst_en_o[k] = ent_q[wb_idx_i[k]].dst_en;
  end

  assign space_o = CW'(ROB_DEPTH) - cnt_q;

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      for (int k = 0; k < GROUP; k++)
        if (wb_valid_i[k]) ent_q[wb_idx_i[k]].done <= 1'b1;
      for (int k = 0; k < GROUP; k++)
        if (alloc_fire_i && alloc_valid_i[k]) ent_q[alloc_idx_o[k]] <= alloc_ent_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + idx_t'(n_ret);
      tail_q <= tail_q + idx_t'(n_alloc);
      cnt_q  <= cnt_q + CW'(n_alloc) - CW'(n_ret);
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(ROB_DEPTH));
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && head_q == '0 && tail_q == '0));
  a_r4_tail_tracks_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(idx_t'(tail_q - head_q)) == (cnt_q & CW'(ROB_DEPTH - 1)));

  for (genvar k = 1; k < GROUP; k++) begin : g_prefix
    a_r6_commit_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_valid_o[k] |-> ret_valid_o[k-1]);
  end
  for (genvar k = 0; k < GROUP; k++) begin : g_wb_chk
    a_r5_wb_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_valid_i[k] && !flush_i) |-> (CW'(idx_t'(wb_idx_i[k] - head_q)) < cnt_q));
  end
endmodule

// File: rtl/rename_commit_unit.sv
module rename_commit_unit
  import rr_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [GROUP-1:0]              alloc_valid_i,
  input  logic [GROUP-1:0]              alloc_dst_en_i,
  input  logic [GROUP-1:0][AW-1:0]      alloc_dst_i,
  input  logic [GROUP-1:0][AW-1:0]      alloc_src_a_i,
  input  logic [GROUP-1:0][AW-1:0]      alloc_src_b_i,
  output logic                          alloc_ready_o,
  output logic [GROUP-1:0][IW-1:0]      alloc_idx_o,
  output logic [GROUP-1:0][PW-1:0]      dst_tag_o,
  output logic [GROUP-1:0][PW-1:0]      src_a_tag_o,
  output logic [GROUP-1:0]              src_a_rdy_o,
  output logic [GROUP-1:0][PW-1:0]      src_b_tag_o,
  output logic [GROUP-1:0]              src_b_rdy_o,
  input  logic [GROUP-1:0]              wb_valid_i,
  input  logic [GROUP-1:0][IW-1:0]      wb_idx_i,
  output logic [GROUP-1:0]              ret_valid_o,
  output logic [GROUP-1:0][AW-1:0]      ret_arch_o,
  output logic [GROUP-1:0][PW-1:0]      ret_tag_o,
  output logic [GROUP-1:0]              ret_free_o,
  output logic [GROUP-1:0][PW-1:0]      ret_free_tag_o
);
  logic [GROUP-1:0]      need_dst;
  logic [GCW-1:0]        n_dst, n_valid;
  logic [GCW-1:0]        take_cnt;
  logic                  fire;
  phys_t [GROUP-1:0]     pick, new_tag, old_tag;
  logic [FCW-1:0]        free_cnt;
  logic [CW-1:0]         space;
  phys_t [ARCH_REGS-1:0] spec_map, com_map;
  rob_ent_t [GROUP-1:0]  alloc_ent, ret_ent;
  logic [GROUP-1:0]      rob_ret_valid, wb_dst_en;
  phys_t [GROUP-1:0]     wb_phys;
  logic [GROUP-1:0]      com_we;
  logic [PHYS_REGS-1:0]  rdy_q;

  assign need_dst = alloc_valid_i & alloc_dst_en_i;

  // rank destination slots to free-list picks
  always_comb begin
    n_dst   = '0;
    n_valid = '0;
    for (int k = 0; k < GROUP; k++) begin
      new_tag[k] = need_dst[k] ? pick[n_dst] : '0;
      if (need_dst[k]) n_dst = n_dst + 1'b1;
      if (alloc_valid_i[k]) n_valid = n_valid + 1'b1;
    end
  end

  assign alloc_ready_o = !flush_i && (free_cnt >= FCW'(n_dst)) && (space >= CW'(n_valid));
  assign fire          = alloc_ready_o && (|alloc_valid_i);
  assign take_cnt      = fire ? n_dst : '0;
  assign dst_tag_o     = new_tag;

  // rename with intra-group forwarding from earlier slots
  always_comb begin
    for (int k = 0; k < GROUP; k++) begin
      src_a_tag_o[k] = spec_map[alloc_src_a_i[k]];
      src_a_rdy_o[k] = rdy_q[src_a_tag_o[k]];
      src_b_tag_o[k] = spec_map[alloc_src_b_i[k]];
      src_b_rdy_o[k] = rdy_q[src_b_tag_o[k]];
      old_tag[k]     = spec_map[alloc_dst_i[k]];
      for (int j = 0; j < k; j++) begin
        if (need_dst[j] && alloc_dst_i[j] == alloc_src_a_i[k]) begin
          src_a_tag_o[k] = new_tag[j];
          src_a_rdy_o[k] = 1'b0;
        end
        if (need_dst[j] && alloc_dst_i[j] == alloc_src_b_i[k]) begin
          src_b_tag_o[k] = new_tag[j];
          src_b_rdy_o[k] = 1'b0;
        end
        if (need_dst[j] && alloc_dst_i[j] == alloc_dst_i[k]) old_tag[k] = new_tag[j];
      end
      alloc_ent[k] = '{done: 1'b0, dst_en: alloc_dst_en_i[k], arch: alloc_dst_i[k],
                       new_p: new_tag[k], old_p: old_tag[k]};
    end
  end

  for (genvar k = 0; k < GROUP; k++) begin : g_ret
    assign com_we[k]         = rob_ret_valid[k] && ret_ent[k].dst_en;
    assign ret_arch_o[k]     = ret_ent[k].arch;
    assign ret_tag_o[k]      = ret_ent[k].new_p;
    assign ret_free_tag_o[k] = ret_ent[k].old_p;
  end
  assign ret_valid_o = rob_ret_valid;
  assign ret_free_o  = com_we;

  rr_free_list u_free (
    .clk_i, .rst_ni, .flush_i,
    .take_cnt_i   (take_cnt),
    .rel_en_i     (com_we),
    .rel_tag_i    (ret_free_tag_o),
    .commit_map_i (com_map),
    .pick_o       (pick),
    .free_cnt_o   (free_cnt)
  );

  rr_alias_table u_rat (
    .clk_i, .rst_ni, .flush_i,
    .spec_we_i   (need_dst & {GROUP{fire}}),
    .spec_arch_i (alloc_dst_i),
    .spec_phys_i (new_tag),
    .com_we_i    (com_we),
    .com_arch_i  (ret_arch_o),
    .com_phys_i  (ret_tag_o),
    .spec_map_o  (spec_map),
    .com_map_o   (com_map)
  );

  rr_rob u_rob (
    .clk_i, .rst_ni, .flush_i,
    .alloc_fire_i  (fire),
    .alloc_valid_i (alloc_valid_i),
    .alloc_ent_i   (alloc_ent),
    .wb_valid_i    (wb_valid_i),
    .wb_idx_i      (wb_idx_i),
    .alloc_idx_o   (alloc_idx_o),
    .space_o       (space),
    .ret_valid_o   (rob_ret_valid),
    .ret_ent_o     (ret_ent),
    .wb_phys_o     (wb_phys),
    .wb_dst_en_o   (wb_dst_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '1;
    end else if (flush_i) begin
      rdy_q <= '1;
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (wb_valid_i[k] && wb_dst_en[k]) rdy_q[wb_phys[k]] <= 1'b1;
      for (int k = 0; k < GROUP; k++)
        if (fire && need_dst[k]) rdy_q[new_tag[k]] <= 1'b0;
    end
  end

  for (genvar k = 0; k < GROUP; k++) begin : g_chk
    a_r5_new_dest_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && need_dst[k]) |=> !rdy_q[$past(new_tag[k])]);
    for (genvar j = 0; j < k; j++) begin : g_pair
      a_r3_distinct_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && need_dst[k] && need_dst[j]) |-> (new_tag[k] != new_tag[j]));
    end
  end
  a_r9_no_accept_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !alloc_ready_o && (ret_valid_o == '0));
endmodule

// File: tb/rename_commit_unit_bench.sv
module rename_commit_unit_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush;
  logic [2:0] a_valid, a_dst_en, src_a_rdy, src_b_rdy, wb_valid, ret_valid, ret_free;
  logic [2:0][2:0] a_dst, a_src_a, a_src_b, ret_arch;
  logic [2:0][5:0] a_idx, dst_tag, src_a_tag, src_b_tag, wb_idx, ret_tag, ret_free_tag;
  logic a_ready;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  rename_commit_unit u_rename_commit_unit (
    .clk_i(clk), .rst_ni, .flush_i(flush),
    .alloc_valid_i(a_valid), .alloc_dst_en_i(a_dst_en), .alloc_dst_i(a_dst),
    .alloc_src_a_i(a_src_a), .alloc_src_b_i(a_src_b),
    .alloc_ready_o(a_ready), .alloc_idx_o(a_idx), .dst_tag_o(dst_tag),
    .src_a_tag_o(src_a_tag), .src_a_rdy_o(src_a_rdy),
    .src_b_tag_o(src_b_tag), .src_b_rdy_o(src_b_rdy),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx),
    .ret_valid_o(ret_valid), .ret_arch_o(ret_arch), .ret_tag_o(ret_tag),
    .ret_free_o(ret_free), .ret_free_tag_o(ret_free_tag)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic idle();
    flush = 0; a_valid = 0; a_dst_en = 0; a_dst = '0; a_src_a = '0; a_src_b = '0;
    wb_valid = 0; wb_idx = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    step();
    rst_ni = 1;
    step();
  endtask

  task automatic slot(int k, bit v, bit de, int d, int sa, int sb);
    a_valid[k] = v; a_dst_en[k] = de; a_dst[k] = 3'(d); a_src_a[k] = 3'(sa); a_src_b[k] = 3'(sb);
  endtask

  task automatic t_reset();
    do_reset();
    slot(0, 0, 0, 0, 0, 7); slot(1, 0, 0, 0, 3, 5); slot(2, 0, 0, 0, 6, 1);
    #1;
    chk("R1 src_a0", src_a_tag[0], 0); chk("R1 src_b0", src_b_tag[0], 7);
    chk("R1 src_a1", src_a_tag[1], 3); chk("R1 src_b2", src_b_tag[2], 1);
    chk("R1 rdy", {src_a_rdy, src_b_rdy}, 6'b111111);
    chk("R1 ready", a_ready, 1); chk("R1 ret", ret_valid, 0);
  endtask

  task automatic t_rename_commit();
    do_reset();
    slot(0, 1, 1, 1, 1, 2); slot(1, 1, 1, 2, 1, 3); slot(2, 1, 1, 1, 2, 1);
    #1;
    chk("R2 s0a", src_a_tag[0], 1); chk("R2 s0a rdy", src_a_rdy[0], 1);
    chk("R2 s1a fwd", src_a_tag[1], 8); chk("R2 s1a rdy", src_a_rdy[1], 0);
    chk("R2 s1b", src_b_tag[1], 3); chk("R2 s2a fwd", src_a_tag[2], 9);
    chk("R2 s2b fwd", src_b_tag[2], 8); chk("R2 s2b rdy", src_b_rdy[2], 0);
    chk("R3 tags", {dst_tag[2], dst_tag[1], dst_tag[0]}, {6'd10, 6'd9, 6'd8});
    chk("R4 idx", {a_idx[2], a_idx[1], a_idx[0]}, {6'd2, 6'd1, 6'd0});
    step();
    idle(); slot(0, 0, 0, 0, 1, 2);
    #1;
    chk("R2 r1 latest", src_a_tag[0], 10); chk("R2 r2 latest", src_b_tag[0], 9);
    chk("R5 r2 pending", src_b_rdy[0], 0);
    wb_valid = 3'b001; wb_idx[0] = 6'd1;
    step();
    wb_valid = 0;
    #1;
    chk("R5 r2 ready", src_b_rdy[0], 1);
    chk("R10 younger waits", ret_valid, 0);
    wb_valid = 3'b001; wb_idx[0] = 6'd0;
    step();
    wb_valid = 0;
    #1;
    chk("R6 stop at incomplete", ret_valid, 3'b011);
    chk("R7 free0", ret_free_tag[0], 1); chk("R7 free1", ret_free_tag[1], 2);
    chk("R6 arch0", ret_arch[0], 1); chk("R6 tag0", ret_tag[0], 8);
    wb_valid = 3'b001; wb_idx[0] = 6'd2;
    step();
    wb_valid = 0;
    #1;
    chk("R6 third", ret_valid, 3'b001);
    chk("R7 free older in group", ret_free_tag[0], 8); chk("R6 tag2", ret_tag[0], 10);
    step();
    #1;
    chk("R6 drained", ret_valid, 0);
    slot(0, 1, 1, 4, 0, 0); slot(1, 1, 1, 5, 0, 0); slot(2, 1, 1, 6, 0, 0);
    #1;
    chk("R7 reuse", {dst_tag[2], dst_tag[1], dst_tag[0]}, {6'd8, 6'd2, 6'd1});
    chk("R4 continue", {a_idx[2], a_idx[1], a_idx[0]}, {6'd5, 6'd4, 6'd3});
    step();
    idle();
  endtask

  task automatic t_compact();
    do_reset();
    slot(0, 1, 1, 2, 0, 0); slot(1, 0, 1, 3, 0, 0); slot(2, 1, 1, 4, 2, 0);
    #1;
    chk("R4 skip idx0", a_idx[0], 0); chk("R4 skip idx2", a_idx[2], 1);
    chk("R3 skip tag2", dst_tag[2], 9); chk("R2 fwd across gap", src_a_tag[2], 8);
    step();
    idle();
  endtask

  task automatic t_rob_full();
    do_reset();
    for (int g = 0; g < 21; g++) begin
      slot(0, 1, 0, 0, 0, 0); slot(1, 1, 0, 0, 0, 0); slot(2, 1, 0, 0, 0, 0);
      step();
    end
    #1;
    chk("R8 rob short", a_ready, 0);
    step();
    a_valid = 3'b001;
    #1;
    chk("R8 one fits", a_ready, 1); chk("R8 stall no effect", a_idx[0], 63);
    step();
    #1;
    chk("R8 rob full", a_ready, 0);
    idle();
  endtask

  task automatic t_free_stall();
    do_reset();
    for (int g = 0; g < 13; g++) begin
      slot(0, 1, 1, 0, 0, 0); slot(1, 1, 1, 1, 0, 0); slot(2, 1, 1, 2, 0, 0);
      step();
    end
    #1;
    chk("R8 pool three", a_ready, 0);
    a_dst_en = 3'b011;
    #1;
    chk("R8 pool two", a_ready, 0);
    step();
    a_dst_en = 3'b100;
    #1;
    chk("R8 pool one", a_ready, 1); chk("R3 last tag", dst_tag[2], 47);
    chk("R8 stall no effect", a_idx[0], 39);
    step();
    idle();
  endtask

  task automatic t_flush();
    do_reset();
    slot(0, 1, 1, 1, 0, 0);
    step();
    idle(); wb_valid = 3'b001; wb_idx[0] = 6'd0;
    step();
    wb_valid = 0;
    step();
    slot(0, 1, 1, 1, 0, 0);
    #1;
    chk("R7 freed reg reused", dst_tag[0], 1);
    step();
    idle(); slot(1, 1, 1, 2, 0, 0); a_valid = 3'b010;
    step();
    idle(); wb_valid = 3'b001; wb_idx[0] = 6'd1;
    step();
    wb_valid = 0;
    #1;
    chk("R6 pending commit", ret_valid, 3'b001);
    flush = 1;
    #1;
    chk("R9 no commit", ret_valid, 0); chk("R9 no accept", a_ready, 0);
    step();
    flush = 0;
    slot(0, 1, 1, 3, 1, 2);
    #1;
    chk("R9 r1 committed", src_a_tag[0], 8); chk("R9 r1 rdy", src_a_rdy[0], 1);
    chk("R9 r2 committed", src_b_tag[0], 2); chk("R9 r2 rdy", src_b_rdy[0], 1);
    chk("R9 empty", ret_valid, 0); chk("R9 idx reset", a_idx[0], 0);
    chk("R9 pool restored", dst_tag[0], 1);
    step();
    idle();
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    idle();
    t_reset();
    t_rename_commit();
    t_compact();
    t_rob_full();
    t_free_stall();
    t_flush();
    finish_run();
  end
endmodule